// File: doc/BRIEF.md
# Two-Stage SPI Bit-Rate Generator

This block makes the serial-clock timing for an SPI engine from the peripheral clock. Two settings in series set the bit period. An 8-bit linear divider `n` sets a base rate that is shared by every transfer. A 2-bit power-of-two selector `N` comes from whichever command is active, and it divides the base rate again by 1, 2, 4 or 8. The serial bit rate is PCLK / (2 × (n + 1) × 2^N). With both values at zero this is half of PCLK. With both values at their maximum it is PCLK / 4096.

The sequencing logic pulses `frame_start_i` once at the start of each frame. On that pulse the block captures both the divider and the selector, and it restarts its count. From then on it gives a strobe every half bit period, which the serial-clock driver uses to toggle the clock line. It also gives a second strobe at the end of every full bit. When `en_i` is low, the block holds its count at the reload value and gives no strobes.

Top module: `spi_bitrate_gen`

## Requirements
- R1: After reset, while `en_i` is low, `sck_tgl_o` and `bit_end_o` are both 0.
- R2: While enabled, consecutive `sck_tgl_o` pulses are exactly (n + 1) × 2^N clock cycles apart. Here n is the captured `div_i` (unsigned) and N is the captured `sel_i` (unsigned).
- R3: `bit_end_o` pulses only together with `sck_tgl_o`, on every second toggle after a frame start. So consecutive `bit_end_o` pulses are 2 × (n + 1) × 2^N cycles apart.
- R4: With n = 0 and N = 0, `sck_tgl_o` is high in every enabled cycle and `bit_end_o` is high every second cycle, which gives half of PCLK.
- R5: With n = 255 and N = 3, toggles are 2048 cycles apart and bit ends are 4096 cycles apart.
- R6: `div_i` and `sel_i` are captured only in a cycle where `frame_start_i` is 1. A change at any other time has no effect on strobe spacing until the next frame start.
- R7: While `en_i` is 0, no strobes are given. After `en_i` returns to 1, the first toggle comes (n + 1) × 2^N cycles later, and it is a leading toggle (no `bit_end_o`).
- R8: No strobe is given in the cycle that `frame_start_i` is high. The first toggle follows (n + 1) × 2^N cycles after that cycle, with the new n and N, and it is a leading toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; when low the count is held and no strobes are given |
| frame_start_i | input | 1 | One-cycle frame start pulse; captures divider and selector |
| div_i | input | 8 | Global linear divider n |
| sel_i | input | 2 | Per-command power-of-two selector N |
| sck_tgl_o | output | 1 | Half-bit-period strobe, used to toggle the serial clock |
| bit_end_o | output | 1 | Strobe at the end of each full bit (trailing toggle) |

## Verification
Two situations are hard to reach from the ports. The first is the largest division, where each bit takes 4096 cycles: the bench runs several whole bits at n = 255, N = 3 and measures the gaps between pulses. The second is a change to the selector or divider in the middle of a frame. The stimulus changes `div_i` and `sel_i` between toggles without a frame pulse and checks that the spacing does not change. It then applies a frame pulse in a cycle where a toggle was due, and checks that the toggle is suppressed and the new spacing takes over. A reference model in the bench, built on integers, predicts both strobes in every cycle.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;
  localparam int unsigned DIV_W_DEF = 8;
  localparam int unsigned SEL_W_DEF = 2;

  typedef enum logic {
    PH_LEAD  = 1'b0,
    PH_TRAIL = 1'b1
  } half_phase_e;
endpackage

// File: rtl/spi_brg_cfg.sv
module spi_brg_cfg #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned SEL_W = 2,
  localparam int unsigned CNT_W = DIV_W + (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_q_o,
  output logic [CNT_W-1:0] reload_o
);
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_use;
  logic [SEL_W-1:0] sel_use;
  logic [CNT_W:0]   base, scaled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sel_q <= '0;
    end else if (capture_i) begin
      div_q <= div_i;
      sel_q <= sel_i;
    end
  end

  // on a capture cycle the counter must load the incoming rate
  assign div_use = capture_i ? div_i : div_q;
  assign sel_use = capture_i ? sel_i : sel_q;

  always_comb begin
    base   = (CNT_W+1)'(div_use) + (CNT_W+1)'(1);
    scaled = base << sel_use;
    reload_o = CNT_W'(scaled - (CNT_W+1)'(1));
  end

  assign sel_q_o = sel_q;
endmodule

// File: rtl/spi_brg_cnt.sv
module spi_brg_cnt #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (load_i || !en_i || cnt_q == '0)  cnt_q <= reload_i;
    else                                      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spi_brg_phase.sv
module spi_brg_phase
  import spi_brg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        step_i,
  output half_phase_e phase_o
);
  half_phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= PH_LEAD;
    else if (clear_i) phase_q <= PH_LEAD;
    else if (step_i)  phase_q <= (phase_q == PH_LEAD) ? PH_TRAIL : PH_LEAD;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/spi_bitrate_gen.sv
module spi_bitrate_gen
  import spi_brg_pkg::*;
#(
  parameter int unsigned DIV_W = DIV_W_DEF,
  parameter int unsigned SEL_W = SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             frame_start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sck_tgl_o,
  output logic             bit_end_o
);
  localparam int unsigned CNT_W = DIV_W + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic             cnt_zero;
  logic             tick;
  half_phase_e      phase_q;

  spi_brg_cfg #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (frame_start_i),
    .div_i     (div_i),
    .sel_i     (sel_i),
    .sel_q_o   (sel_q),
    .reload_o  (reload_w)
  );

  spi_brg_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .load_i   (frame_start_i),
    .reload_i (reload_w),
    .cnt_o    (cnt_q),
    .zero_o   (cnt_zero)
  );

  // frame start wins over a due tick
  assign tick = en_i & cnt_zero & ~frame_start_i;

  spi_brg_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (frame_start_i | ~en_i),
    .step_i  (tick),
    .phase_o (phase_q)
  );

  assign sck_tgl_o = tick;
  assign bit_end_o = tick & (phase_q == PH_TRAIL);
endmodule

// File: rtl/spi_bitrate_gen_chk.sv
module spi_bitrate_gen_chk #(
  parameter int unsigned CNT_W = 11,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             frame_start_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             sck_tgl_o,
  input logic             bit_end_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_w,
  input logic [SEL_W-1:0] sel_q,
  input logic             phase_q
);
  // R3
  bit_end_with_tgl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_end_o |-> sck_tgl_o);

  // R2
  reload_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_tgl_o && !frame_start_i) |=> (cnt_q == $past(reload_w)));

  // R2
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !frame_start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6
  sel_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (sel_q == $past(sel_i)));

  // R6
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(sel_q));

  // R7
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !frame_start_i) |=> (cnt_q == $past(reload_w) && !phase_q));

  // R3
  phase_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_tgl_o && en_i) |=> (phase_q != $past(phase_q)));

  // R8
  frame_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> !sck_tgl_o);
endmodule

bind spi_bitrate_gen spi_bitrate_gen_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .frame_start_i (frame_start_i),
  .sel_i         (sel_i),
  .sck_tgl_o     (sck_tgl_o),
  .bit_end_o     (bit_end_o),
  .cnt_q         (cnt_q),
  .reload_w      (reload_w),
  .sel_q         (sel_q),
  .phase_q       (phase_q)
);

// File: tb/spi_bitrate_gen_tb.sv
module spi_bitrate_gen_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       frame_start_i = 1'b0;
  logic [7:0] div_i = '0;
  logic [1:0] sel_i = '0;
  logic       sck_tgl_o, bit_end_o;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  spi_bitrate_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .frame_start_i(frame_start_i),
    .div_i(div_i), .sel_i(sel_i), .sck_tgl_o(sck_tgl_o), .bit_end_o(bit_end_o)
  );

  // behavioural reference model
  int m_n = 0, m_sel = 0, m_cnt = 0, m_ph = 0;
  int cyc = 0, last_tgl = -1, last_be = -1;

  function automatic int gap(input int n, input int s);
    return (n + 1) * (1 << s);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_n = 0; m_sel = 0; m_cnt = 0; m_ph = 0;
    end else if (frame_start_i) begin
      m_n = div_i; m_sel = sel_i; m_cnt = gap(m_n, m_sel) - 1; m_ph = 0;
    end else if (!en_i) begin
      m_cnt = gap(m_n, m_sel) - 1; m_ph = 0;
    end else if (m_cnt == 0) begin
      m_cnt = gap(m_n, m_sel) - 1; m_ph = 1 - m_ph;
    end else begin
      m_cnt = m_cnt - 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    int e_tgl, e_be;
    cyc++;
    if (rst_ni) begin
      e_tgl = (en_i && !frame_start_i && m_cnt == 0) ? 1 : 0;
      e_be  = (e_tgl == 1 && m_ph == 1) ? 1 : 0;
      check({tag, " tgl"}, sck_tgl_o, e_tgl);
      check({tag, " bit_end"}, bit_end_o, e_be);
      if (frame_start_i || !en_i) begin
        last_tgl = -1; last_be = -1;
      end else begin
        if (sck_tgl_o) begin
          if (last_tgl >= 0) begin
            if (m_n == 0 && m_sel == 0)       check("R4 gap", cyc - last_tgl, 1);
            else if (m_n == 255 && m_sel == 3) check("R5 gap", cyc - last_tgl, 2048);
            else                               check("R2 gap", cyc - last_tgl, gap(m_n, m_sel));
          end
          last_tgl = cyc;
        end
        if (bit_end_o) begin
          if (last_be >= 0) check("R3 bit gap", cyc - last_be, 2 * gap(m_n, m_sel));
          last_be = cyc;
        end
      end
    end else begin
      check("R1 reset tgl", sck_tgl_o, 0);
      check("R1 reset bit_end", bit_end_o, 0);
    end
  end

  task automatic wait_cyc(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic frame(input int n, input int s, input int run);
    div_i = 8'(n); sel_i = 2'(s); frame_start_i = 1'b1;
    wait_cyc(1);
    frame_start_i = 1'b0;
    wait_cyc(run);
  endtask

  initial begin
    #1;
    wait_cyc(3);
    rst_ni = 1'b1;
    tag = "R1";
    wait_cyc(5);
    // R4 fastest rate
    tag = "R4"; en_i = 1'b1;
    frame(0, 0, 12);
    // R2 / R3 several pairs
    tag = "R2"; frame(3, 0, 40);
    tag = "R2"; frame(1, 2, 60);
    tag = "R3"; frame(5, 1, 80);
    tag = "R2"; frame(0, 3, 50);
    // R6 mid-frame change ignored
    tag = "R6"; frame(2, 1, 15);
    div_i = 8'd9; sel_i = 2'd3;
    wait_cyc(40);
    // R8 frame start where a toggle is due
    tag = "R8"; frame(4, 0, 4);
    frame(1, 1, 30);
    // R7 disable and re-enable
    tag = "R7"; en_i = 1'b0;
    wait_cyc(20);
    en_i = 1'b1;
    wait_cyc(30);
    // R5 slowest rate
    tag = "R5"; frame(255, 3, 3 * 4096 + 10);
    en_i = 1'b0;
    wait_cyc(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule